// File: doc/BRIEF.md
# Clock Source Selector with Failure Fallback

This block chooses which of two oscillators drives the system clock. After reset the internal RC oscillator is in charge. Software may then request the external oscillator, which is meant for the 4 to 24 MHz range. While the external source is requested and monitoring is on, the block watches it. If the external clock stops toggling, the block returns the system clock to the internal oscillator by itself. It also sets a sticky failure flag and, if enabled, raises an interrupt.

Every change of source is glitch-free. The branch being left is gated off on a falling edge of its own clock. Only after that does the new branch open, on a falling edge of its own clock. A minimum dwell time between selection changes gives each handshake time to complete. All control inputs belong to the internal-clock domain. The status output tells software which source is actually driving the clock at that moment.

Top module: `clk_failover_sel`

## Requirements
- R1: During and after a reset, clk_sys follows clk_int, and src_is_ext, fail_flag and irq are all 0.
- R2: When sel_ext_req is 1 and fail_flag is 0, the block switches to the external source. Once SWITCH_HOLD (16) clk_int cycles have passed since the last selection change and a few clk_ext cycles for the handshake, clk_sys follows clk_ext and src_is_ext is 1 (1 means external, 0 means internal).
- R3: When sel_ext_req returns to 0, clk_sys goes back to clk_int and src_is_ext reads 0.
- R4: With mon_en at 1 and the external source selected, failure is declared when no clk_ext rising edge is seen for FAIL_LIMIT (32) clk_int cycles. Failure is not declared before that, even 20 cycles after the clock stops. Once declared, fail_flag is 1 and clk_sys follows clk_int again.
- R5: With mon_en at 0, a stopped external clock never sets fail_flag.
- R6: fail_flag stays 1 until a one-cycle pulse on flag_clr. While it is 1, a request on sel_ext_req is ignored, and src_is_ext stays 0.
- R7: irq equals fail_flag AND irq_en, one clk_int cycle later.
- R8: No high or low phase of clk_sys is shorter than the shorter half period of the two source clocks.
- R9: An external clock that is slow but toggles within the monitoring window does not cause a failure.
- R10: After fail_flag is cleared with sel_ext_req still 1, the block switches back to the external source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal RC oscillator; also clocks all control logic |
| clk_ext | input | 1 | External oscillator |
| rst | input | 1 | Synchronous active-high reset, clk_int domain |
| sel_ext_req | input | 1 | Level request to run from the external source |
| mon_en | input | 1 | Enables the external-clock failure monitor |
| irq_en | input | 1 | Enables the failure interrupt |
| flag_clr | input | 1 | Pulse that clears the failure flag |
| clk_sys | output | 1 | Gated system clock |
| src_is_ext | output | 1 | 1 while the external source drives clk_sys |
| fail_flag | output | 1 | Sticky failure indication |
| irq | output | 1 | Failure interrupt request |

## Verification
Some properties are checked by assertions on every internal clock edge. These are: the two clock gates are never open together, a failure always sets the flag, a set flag keeps the external selection off, the selection changes only after the dwell time, the interrupt follows flag and enable, and a disabled monitor never reports failure. Other behaviour only shows in the bench's scenarios. That covers whether clk_sys really tracks the chosen oscillator, the exact failure window after the external clock stops, the absence of short clock phases, and recovery after the flag is cleared.

// File: rtl/clkfo_pkg.sv
package clkfo_pkg;
  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } clk_src_e;

  localparam int DEF_FAIL_LIMIT  = 32;
  localparam int DEF_SWITCH_HOLD = 16;
  localparam int DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/clkfo_sync.sv
module clkfo_sync #(
  parameter int STAGES    = 2,
  parameter bit RST_VAL   = 1'b0,
  parameter bit ASYNC_RST = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or posedge rst) begin
        if (rst) pipe <= {STAGES{RST_VAL}};
        else     pipe <= {pipe[STAGES-2:0], d};
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) pipe <= {STAGES{RST_VAL}};
        else     pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/clkfo_monitor.sv
module clkfo_monitor #(
  parameter int FAIL_LIMIT  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_int,
  input  logic clk_ext,
  input  logic rst,
  input  logic active,
  output logic fail_pulse
);
  localparam int CNT_W = (FAIL_LIMIT > 2) ? $clog2(FAIL_LIMIT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FAIL_LIMIT - 1);

  logic             tog_ext;
  logic             tog_s;
  logic             tog_d;
  logic             seen;
  logic [CNT_W-1:0] idle_cnt;

  // divide-by-two marker in the external domain
  always_ff @(posedge clk_ext or posedge rst) begin
    if (rst) tog_ext <= 1'b0;
    else     tog_ext <= ~tog_ext;
  end

  clkfo_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .ASYNC_RST(1'b0)) u_tog_sync (
    .clk (clk_int),
    .rst (rst),
    .d   (tog_ext),
    .q   (tog_s)
  );

  assign seen = tog_s ^ tog_d;

  always_ff @(posedge clk_int) begin
    if (rst) begin
      tog_d      <= 1'b0;
      idle_cnt   <= '0;
      fail_pulse <= 1'b0;
    end else begin
      tog_d      <= tog_s;
      fail_pulse <= 1'b0;
      if (!active || seen) begin
        idle_cnt <= '0;
      end else if (idle_cnt == CNT_LAST) begin
        idle_cnt   <= '0;
        fail_pulse <= 1'b1;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  a_r5_idle_no_fail: assert property (@(posedge clk_int) disable iff (rst)
    !active |=> !fail_pulse);
  a_r4_window_bound: assert property (@(posedge clk_int) disable iff (rst)
    fail_pulse |-> $past(active));
endmodule

// File: rtl/clkfo_ctrl.sv
module clkfo_ctrl #(
  parameter int SWITCH_HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_req,
  input  logic irq_en,
  input  logic flag_clr,
  input  logic fail_pulse,
  output logic sel_ext,
  output logic fail_flag,
  output logic irq,
  output logic ext_kill
);
  localparam int HOLD_W = $clog2(SWITCH_HOLD + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(SWITCH_HOLD);

  logic [HOLD_W-1:0] hold_cnt;
  logic              sel_want;
  logic              flag_next;

  assign sel_want  = sel_req & ~fail_flag;
  assign flag_next = fail_pulse | (fail_flag & ~flag_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_ext   <= 1'b0;
      fail_flag <= 1'b0;
      irq       <= 1'b0;
      ext_kill  <= 1'b1;
      hold_cnt  <= '0;
    end else begin
      fail_flag <= flag_next;
      ext_kill  <= flag_next;
      irq       <= fail_flag & irq_en;
      if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      if (fail_pulse) begin
        sel_ext  <= 1'b0;
        hold_cnt <= HOLD_LOAD;
      end else if (hold_cnt == '0 && sel_want != sel_ext) begin
        sel_ext  <= sel_want;
        hold_cnt <= HOLD_LOAD;
      end
    end
  end

  a_r4_fail_sets_flag: assert property (@(posedge clk) disable iff (rst)
    fail_pulse |=> fail_flag);
  a_r6_flag_blocks_sel: assert property (@(posedge clk) disable iff (rst)
    fail_flag |=> !sel_ext);
  a_r2_dwell_respected: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_ext) |-> $past(hold_cnt == '0));
  a_r7_irq_masked: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);
  a_r7_irq_raised: assert property (@(posedge clk) disable iff (rst)
    (fail_flag && irq_en) |=> irq);
endmodule

// File: rtl/clkfo_gate_mux.sv
module clkfo_gate_mux
  import clkfo_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_int,
  input  logic clk_ext,
  input  logic rst,
  input  logic ext_kill,
  input  logic sel_ext,
  output logic clk_sys,
  output logic src_is_ext
);
  logic     int_arm;
  logic     int_gate;
  logic     ext_want;
  logic     ext_arm;
  logic     ext_gate;
  logic     ext_gate_s;
  clk_src_e src_q;

  // internal branch: opens only once the external gate is seen closed
  clkfo_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .ASYNC_RST(1'b0)) u_ext_back (
    .clk (clk_int),
    .rst (rst),
    .d   (ext_gate),
    .q   (ext_gate_s)
  );

  always_ff @(posedge clk_int) begin
    if (rst) begin
      int_arm <= 1'b1;
      src_q   <= SRC_INT;
    end else begin
      int_arm <= ~sel_ext & ~ext_gate_s;
      src_q   <= ext_gate_s ? SRC_EXT : SRC_INT;
    end
  end

  always_ff @(negedge clk_int) begin
    if (rst) int_gate <= 1'b1;
    else     int_gate <= int_arm;
  end

  // external branch: cleared at once on failure, the clock may be dead
  assign ext_want = sel_ext & ~int_gate;

  clkfo_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .ASYNC_RST(1'b1)) u_ext_fwd (
    .clk (clk_ext),
    .rst (ext_kill),
    .d   (ext_want),
    .q   (ext_arm)
  );

  always_ff @(negedge clk_ext or posedge ext_kill) begin
    if (ext_kill) ext_gate <= 1'b0;
    else          ext_gate <= ext_arm;
  end

  assign clk_sys    = (clk_int & int_gate) | (clk_ext & ext_gate);
  assign src_is_ext = (src_q == SRC_EXT);

  a_r8_gates_exclusive: assert property (@(posedge clk_int) disable iff (rst)
    !(int_gate && ext_gate));
  a_r3_int_waits_ext: assert property (@(posedge clk_int) disable iff (rst)
    $rose(int_arm) |-> !ext_gate_s);
endmodule

// File: rtl/clk_failover_sel.sv
module clk_failover_sel
  import clkfo_pkg::*;
#(
  parameter int FAIL_LIMIT  = DEF_FAIL_LIMIT,
  parameter int SWITCH_HOLD = DEF_SWITCH_HOLD,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk_int,
  input  logic clk_ext,
  input  logic rst,
  input  logic sel_ext_req,
  input  logic mon_en,
  input  logic irq_en,
  input  logic flag_clr,
  output logic clk_sys,
  output logic src_is_ext,
  output logic fail_flag,
  output logic irq
);
  logic sel_ext;
  logic ext_kill;
  logic fail_pulse;
  logic mon_active;

  assign mon_active = mon_en & sel_ext;

  clkfo_ctrl #(.SWITCH_HOLD(SWITCH_HOLD)) u_ctrl (
    .clk        (clk_int),
    .rst        (rst),
    .sel_req    (sel_ext_req),
    .irq_en     (irq_en),
    .flag_clr   (flag_clr),
    .fail_pulse (fail_pulse),
    .sel_ext    (sel_ext),
    .fail_flag  (fail_flag),
    .irq        (irq),
    .ext_kill   (ext_kill)
  );

  clkfo_monitor #(.FAIL_LIMIT(FAIL_LIMIT), .SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk_int    (clk_int),
    .clk_ext    (clk_ext),
    .rst        (rst),
    .active     (mon_active),
    .fail_pulse (fail_pulse)
  );

  clkfo_gate_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .clk_int    (clk_int),
    .clk_ext    (clk_ext),
    .rst        (rst),
    .ext_kill   (ext_kill),
    .sel_ext    (sel_ext),
    .clk_sys    (clk_sys),
    .src_is_ext (src_is_ext)
  );
endmodule

// File: tb/clk_failover_sel_test.sv
`timescale 1ns/1ps
module clk_failover_sel_test;
  logic clk_int = 1'b0;
  logic clk_ext = 1'b0;
  logic rst = 1'b1;
  logic sel_ext_req = 1'b0;
  logic mon_en = 1'b0;
  logic irq_en = 1'b0;
  logic flag_clr = 1'b0;
  logic clk_sys, src_is_ext, fail_flag, irq;

  realtime ext_half = 5.0;
  bit      ext_run  = 1'b1;
  bit      glitch_on = 1'b0;
  int      n_sys = 0, n_ext = 0, glitches = 0;
  int      n_chk = 0, n_err = 0;
  realtime last_edge = 0.0;
  localparam realtime MIN_PHASE = 3.0;

  clk_failover_sel uut (
    .clk_int(clk_int), .clk_ext(clk_ext), .rst(rst),
    .sel_ext_req(sel_ext_req), .mon_en(mon_en), .irq_en(irq_en),
    .flag_clr(flag_clr), .clk_sys(clk_sys), .src_is_ext(src_is_ext),
    .fail_flag(fail_flag), .irq(irq)
  );

  always #4 clk_int = ~clk_int;

  always begin
    #(ext_half);
    if (ext_run) clk_ext = ~clk_ext;
    else         clk_ext = 1'b0;
  end

  always @(posedge clk_sys) n_sys++;
  always @(posedge clk_ext) n_ext++;
  always @(clk_sys) begin
    if (glitch_on && ($realtime - last_edge) < MIN_PHASE - 0.05) glitches++;
    last_edge = $realtime;
  end

  function automatic bit exp_src(bit req, bit flag);
    return req & ~flag;
  endfunction

  function automatic bit exp_irq(bit flag, bit en);
    return flag & en;
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk_int);
    @(negedge clk_int);
  endtask

  task automatic follows_ext(input string rq);
    int s0 = n_sys;
    int e0 = n_ext;
    int ds, de;
    tick(20);
    ds = n_sys - s0;
    de = n_ext - e0;
    check(ds - de <= 1 && de - ds <= 1, rq, ds, de);
  endtask

  task automatic follows_int(input string rq);
    int s0 = n_sys;
    int ds;
    tick(20);
    ds = n_sys - s0;
    check(ds >= 19 && ds <= 21, rq, ds, 20);
  endtask

  task automatic stop_ext();
    @(negedge clk_ext);
    ext_run = 1'b0;
    @(negedge clk_int);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(8.0 * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    tick(6);
    // R1: state while in reset and just after it
    check(src_is_ext == 1'b0, "R1 src in reset", src_is_ext, 0);
    rst = 1'b0;
    tick(4);
    check(fail_flag == 1'b0, "R1 flag", fail_flag, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(src_is_ext == 1'b0, "R1 src", src_is_ext, 0);
    follows_int("R1 clk_sys follows clk_int");
    glitch_on = 1'b1;

    // R2: switch to external
    mon_en = 1'b1; irq_en = 1'b1; sel_ext_req = 1'b1;
    tick(40);
    check(src_is_ext == exp_src(1, 0), "R2 src ext", src_is_ext, 1);
    follows_ext("R2 clk_sys follows clk_ext");

    // R3: back to internal
    sel_ext_req = 1'b0;
    tick(40);
    check(src_is_ext == 1'b0, "R3 src int", src_is_ext, 0);
    follows_int("R3 clk_sys follows clk_int");

    // R4: failure detection window
    sel_ext_req = 1'b1;
    tick(40);
    check(src_is_ext == 1'b1, "R4 pre src", src_is_ext, 1);
    stop_ext();
    tick(20);
    check(fail_flag == 1'b0, "R4 not early", fail_flag, 0);
    tick(30);
    check(fail_flag == 1'b1, "R4 flag set", fail_flag, 1);
    check(src_is_ext == 1'b0, "R4 fallback src", src_is_ext, 0);
    follows_int("R4 clk_sys back on clk_int");
    check(irq == exp_irq(fail_flag, irq_en), "R7 irq on fail", irq, 1);

    // R6: flag sticky, request ignored
    ext_run = 1'b1;
    tick(40);
    check(src_is_ext == 1'b0, "R6 request ignored", src_is_ext, 0);
    check(fail_flag == 1'b1, "R6 flag sticky", fail_flag, 1);

    // R7: mask then unmask
    irq_en = 1'b0;
    tick(2);
    check(irq == exp_irq(fail_flag, irq_en), "R7 masked", irq, 0);
    irq_en = 1'b1;
    tick(2);
    check(irq == exp_irq(fail_flag, irq_en), "R7 unmasked", irq, 1);

    // R10: clear with request held
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    tick(40);
    check(fail_flag == 1'b0, "R10 flag cleared", fail_flag, 0);
    check(irq == 1'b0, "R7 irq after clear", irq, 0);
    check(src_is_ext == 1'b1, "R10 back on ext", src_is_ext, 1);
    follows_ext("R10 clk_sys follows clk_ext");

    // R5: monitor off, dead clock tolerated
    mon_en = 1'b0;
    stop_ext();
    tick(80);
    check(fail_flag == 1'b0, "R5 no fail when off", fail_flag, 0);
    check(src_is_ext == 1'b1, "R5 src stays ext", src_is_ext, 1);
    ext_run = 1'b1;
    tick(5);
    sel_ext_req = 1'b0;
    tick(40);
    check(src_is_ext == 1'b0, "R5 leave ext", src_is_ext, 0);

    // R9: slow but live external clock
    mon_en = 1'b1;
    ext_half = 50.0;
    tick(10);
    sel_ext_req = 1'b1;
    tick(150);
    check(src_is_ext == 1'b1, "R9 slow ext selected", src_is_ext, 1);
    check(fail_flag == 1'b0, "R9 no false fail", fail_flag, 0);
    sel_ext_req = 1'b0;
    tick(150);
    check(src_is_ext == 1'b0, "R9 slow ext released", src_is_ext, 0);
    ext_half = 5.0;
    tick(10);

    // random phase: R2 and R3 under varied periods
    for (int i = 0; i < 16; i++) begin
      ext_half = 3.0 + real'($urandom % 5);
      sel_ext_req = 1'($urandom % 2);
      tick(48);
      check(src_is_ext == exp_src(sel_ext_req, 0), "R2 R3 random src", src_is_ext,
            int'(exp_src(sel_ext_req, 0)));
      check(fail_flag == 1'b0, "R9 random no fail", fail_flag, 0);
      if (sel_ext_req) follows_ext("R2 random follow ext");
      else             follows_int("R3 random follow int");
    end

    // R8: no short phases seen on clk_sys
    check(glitches == 0, "R8 glitch-free", glitches, 0);
    finish_run();
  end
endmodule